// File: doc/BRIEF.md
# Multi-size cyclic shift network

This block rotates a vector of message symbols cyclically for a rotation size chosen at run time. The vector holds up to `ZMAX` lanes, and only the lowest `z` lanes carry data. A result lane `i` below `z` takes input lane `(i + p) mod z`. Lanes at and above `z` are filler on the input and are zero on the output. The block is meant as the exchange network between the message stores and the node processors of a quasi-cyclic decoder. It has no tag bits inside the messages.

The datapath has three stages. First, one fixed barrel shifter of width `ZMAX` rotates every lane by `p`, modulo `ZMAX`. Second, two candidate windows are taken from that rotated vector. The upper window covers rotated lanes `ZMAX-z` through `ZMAX-1`. The lower window covers rotated lanes `0` through `z-1`. Third, each result lane picks its symbol from one of these windows. Lanes below `z-p` pick from the lower window. Lanes from `z-p` up to `z-1` pick from the upper window. The control part works out the split point and the strobes. An optional register stage holds the result. A valid flag is delayed to match it.

Top module: `multi_size_rotator`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is 0 and every lane of `outData` is 0 until the first accepted vector. Lane `k` occupies bits `[9k+8:9k]`.
- R2: For an accepted vector with size `z` and shift `p`, where `0 <= p < z`, result lane `i < z` equals input lane `(i + p) mod z`.
- R3: Every result lane `i >= z` is 0.
- R4: Input lanes at positions `>= z` have no effect on the result.
- R5: With `p = 0`, result lanes below `z` equal the input lanes.
- R6: The result is correct for shifts above `ZMAX/2` as well as below it. Test cases include `z=96, p=70` and `z=81, p=60`.
- R7: Every size from 24 to 96 in steps of 4 is supported, and so are 27, 54 and 81.
- R8: With the register stage enabled, which is the default, `outValid` is `inValid` delayed by one clock. `outData` keeps its last result in any cycle where `inValid` is low.
- R9: The extreme shifts `p = 1` and `p = z-1` give correct rotations at the smallest size (24) and at the largest size (96).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input vector, size and shift are presented this cycle |
| inData | input | ZMAX*SYM_W (864) | Input symbols, lane k at bits [SYM_W*k +: SYM_W] |
| zSize | input | 7 | Rotation size z |
| shiftAmt | input | 7 | Shift amount p, less than z |
| outValid | output | 1 | Result is valid |
| outData | output | ZMAX*SYM_W (864) | Rotated symbols, lanes at or above z are zero |

## Verification
The directed vectors use symbols that are distinct in every lane. This way a rotation taken modulo `ZMAX` instead of modulo `z` shows up as a wrong symbol in the upper-window lanes. Shifts are placed on both sides of `ZMAX/2`, and at `p = 1` and `p = z-1`, so that both window boundaries and the split point are exercised. The same lower lanes are sent twice with different random filler. A change in the result then reveals any leak from the unused lanes. A sweep over all legal sizes, followed by random size and shift pairs, compares each lane against a plain modular-index model.

// File: rtl/shiftnet_pkg.sv
package shiftnet_pkg;
  parameter int ZMAX_DEF  = 96;
  parameter int SYM_W_DEF = 9;
  // counter width for sizes and shifts, covers ZMAX up to 255
  parameter int CNT_W     = 8;

  typedef struct packed {
    logic             loadEn;  // capture result this cycle
    logic [CNT_W-1:0] zLen;    // active lanes
    logic [CNT_W-1:0] shift;   // rotation amount
    logic [CNT_W-1:0] split;   // first lane served by the upper window
  } strobe_t;
endpackage

// File: rtl/shiftnet_ctrl.sv
module shiftnet_ctrl
  import shiftnet_pkg::*;
#(
  parameter int ZW   = 7,
  parameter int PIPE = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [ZW-1:0] zSize,
  input  logic [ZW-1:0] shiftAmt,
  output strobe_t       strb,
  output logic          validOut
);
  logic [CNT_W-1:0] zExt;
  logic [CNT_W-1:0] pExt;

  assign zExt = CNT_W'(zSize);
  assign pExt = CNT_W'(shiftAmt);

  always_comb begin
    strb.loadEn = inValid;
    strb.zLen   = zExt;
    strb.shift  = pExt;
    strb.split  = zExt - pExt;
  end

  if (PIPE != 0) begin : g_regValid
    logic validQ;
    always_ff @(posedge clk) begin
      if (!rstN) validQ <= 1'b0;
      else       validQ <= inValid;
    end
    assign validOut = validQ;
  end else begin : g_passValid
    assign validOut = inValid;
  end
endmodule

// File: rtl/shiftnet_dp.sv
module shiftnet_dp
  import shiftnet_pkg::*;
#(
  parameter int ZMAX  = 96,
  parameter int SYM_W = 9,
  parameter int PIPE  = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ZMAX*SYM_W-1:0] inData,
  input  strobe_t               strb,
  output logic [ZMAX*SYM_W-1:0] outData
);
  localparam int LW = $clog2(ZMAX);
  localparam int IW = CNT_W + 1;

  logic [SYM_W-1:0]      srcLane [ZMAX];
  logic [SYM_W-1:0]      rotLane [ZMAX];
  logic [ZMAX*SYM_W-1:0] pickFlat;

  for (genvar g = 0; g < ZMAX; g++) begin : g_lane
    logic [IW-1:0]    sumRaw;
    logic [IW-1:0]    rotIdx;
    logic [IW-1:0]    winAIdx;
    logic [SYM_W-1:0] winA;
    logic [SYM_W-1:0] winB;

    assign srcLane[g] = inData[g*SYM_W +: SYM_W];

    // stage 1: full-width rotation modulo ZMAX
    assign sumRaw     = IW'(g) + IW'(strb.shift);
    assign rotIdx     = (sumRaw >= IW'(ZMAX)) ? sumRaw - IW'(ZMAX) : sumRaw;
    assign rotLane[g] = srcLane[rotIdx[LW-1:0]];

    // stage 2: candidate windows
    assign winAIdx = IW'(ZMAX + g) - IW'(strb.zLen);
    assign winA    = (winAIdx < IW'(ZMAX)) ? rotLane[winAIdx[LW-1:0]] : '0;
    assign winB    = rotLane[g];

    // stage 3: per-lane select
    always_comb begin
      if (IW'(g) >= IW'(strb.zLen))      pickFlat[g*SYM_W +: SYM_W] = '0;
      else if (IW'(g) < IW'(strb.split)) pickFlat[g*SYM_W +: SYM_W] = winB;
      else                               pickFlat[g*SYM_W +: SYM_W] = winA;
    end
  end

  if (PIPE != 0) begin : g_regOut
    logic [ZMAX*SYM_W-1:0] outQ;
    always_ff @(posedge clk) begin
      if (!rstN)            outQ <= '0;
      else if (strb.loadEn) outQ <= pickFlat;
    end
    assign outData = outQ;
  end else begin : g_combOut
    assign outData = pickFlat;
  end
endmodule

// File: rtl/multi_size_rotator.sv
module multi_size_rotator
  import shiftnet_pkg::*;
#(
  parameter int ZMAX  = ZMAX_DEF,
  parameter int SYM_W = SYM_W_DEF,
  parameter int PIPE  = 1,
  localparam int ZW   = $clog2(ZMAX + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [ZMAX*SYM_W-1:0] inData,
  input  logic [ZW-1:0]         zSize,
  input  logic [ZW-1:0]         shiftAmt,
  output logic                  outValid,
  output logic [ZMAX*SYM_W-1:0] outData
);
  strobe_t strb;

  shiftnet_ctrl #(.ZW(ZW), .PIPE(PIPE)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .zSize(zSize),
    .shiftAmt(shiftAmt), .strb(strb), .validOut(outValid)
  );

  shiftnet_dp #(.ZMAX(ZMAX), .SYM_W(SYM_W), .PIPE(PIPE)) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .strb(strb), .outData(outData)
  );
endmodule

// File: rtl/shiftnet_chk.sv
module shiftnet_chk #(
  parameter int ZMAX  = 96,
  parameter int SYM_W = 9,
  parameter int PIPE  = 1,
  parameter int ZW    = 7
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic [ZMAX*SYM_W-1:0] inData,
  input logic [ZW-1:0]         zSize,
  input logic [ZW-1:0]         shiftAmt,
  input logic                  outValid,
  input logic [ZMAX*SYM_W-1:0] outData
);
  logic                  prevValid;
  logic [ZW-1:0]         prevZ;
  logic [ZW-1:0]         prevP;
  logic [ZMAX*SYM_W-1:0] prevIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevZ     <= '0;
      prevP     <= '0;
      prevIn    <= '0;
    end else begin
      prevValid <= inValid;
      prevZ     <= zSize;
      prevP     <= shiftAmt;
      prevIn    <= inData;
    end
  end

  logic highBad;
  logic passBad;
  logic lane0Ok;

  always_comb begin
    highBad = 1'b0;
    passBad = 1'b0;
    for (int k = 0; k < ZMAX; k++) begin
      if (k >= int'(prevZ) && outData[k*SYM_W +: SYM_W] != '0) highBad = 1'b1;
      if (k < int'(prevZ) && outData[k*SYM_W +: SYM_W] != prevIn[k*SYM_W +: SYM_W])
        passBad = 1'b1;
    end
    lane0Ok = (outData[SYM_W-1:0] == prevIn[int'(prevP)*SYM_W +: SYM_W]);
  end

  if (PIPE != 0) begin : g_props
    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
      outValid == $past(inValid));
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
      !$past(inValid) |-> $stable(outData));
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
      prevValid |-> !highBad);
    assert_lane0_rot_R2: assert property (@(posedge clk) disable iff (!rstN)
      (prevValid && prevP < prevZ) |-> lane0Ok);
    assert_zero_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
      (prevValid && prevP == '0) |-> !passBad);
  end
endmodule

bind multi_size_rotator shiftnet_chk #(
  .ZMAX(ZMAX), .SYM_W(SYM_W), .PIPE(PIPE), .ZW(ZW)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .zSize(zSize),
  .shiftAmt(shiftAmt), .outValid(outValid), .outData(outData)
);

// File: tb/multi_size_rotator_tb.sv
module multi_size_rotator_tb;
  localparam int ZMAX  = 96;
  localparam int SYM_W = 9;
  localparam int ZW    = 7;
  localparam int VW    = ZMAX * SYM_W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [VW-1:0] inData = '0;
  logic [ZW-1:0] zSize = '0;
  logic [ZW-1:0] shiftAmt = '0;
  logic          outValid;
  logic [VW-1:0] outData;

  int errCnt = 0;
  int chkCnt = 0;

  always #10 clk = ~clk;

  multi_size_rotator u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .zSize(zSize),
    .shiftAmt(shiftAmt), .outValid(outValid), .outData(outData)
  );

  function automatic logic [VW-1:0] makeVec(int z, int seed);
    logic [VW-1:0] v;
    for (int k = 0; k < ZMAX; k++) begin
      if (k < z) v[k*SYM_W +: SYM_W] = SYM_W'((k * 5 + seed * 13 + 1) % 512);
      else       v[k*SYM_W +: SYM_W] = SYM_W'($urandom);
    end
    return v;
  endfunction

  function automatic logic [VW-1:0] refRot(logic [VW-1:0] v, int z, int p);
    logic [VW-1:0] r;
    r = '0;
    for (int i = 0; i < z; i++) r[i*SYM_W +: SYM_W] = v[((i + p) % z)*SYM_W +: SYM_W];
    return r;
  endfunction

  task automatic compareVec(logic [VW-1:0] exp, string tag);
    chkCnt++;
    for (int i = 0; i < ZMAX; i++) begin
      if (outData[i*SYM_W +: SYM_W] !== exp[i*SYM_W +: SYM_W]) begin
        errCnt++;
        $display("FAIL %s lane %0d actual=%0h expected=%0h", tag, i,
                 outData[i*SYM_W +: SYM_W], exp[i*SYM_W +: SYM_W]);
        return;
      end
    end
  endtask

  task automatic checkBit(logic act, logic exp, string tag);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // drive on falling edge, result appears after next rising edge
  task automatic sendOne(logic [VW-1:0] v, int z, int p);
    @(negedge clk);
    inData = v; zSize = ZW'(z); shiftAmt = ZW'(p); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runOne(int z, int p, int seed, string tag);
    logic [VW-1:0] v;
    v = makeVec(z, seed);
    sendOne(v, z, p);
    checkBit(outValid, 1'b1, {tag, " valid R8"});
    compareVec(refRot(v, z, p), tag);
  endtask

  task automatic testReset;
    checkBit(outValid, 1'b0, "R1 valid in reset");
    compareVec('0, "R1 data in reset");
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    checkBit(outValid, 1'b0, "R1 valid after reset");
    compareVec('0, "R1 data after reset");
  endtask

  task automatic testSmallShift;
    runOne(24, 5, 1, "R2 z24 p5");
    runOne(40, 17, 2, "R2 z40 p17");
    runOne(64, 30, 3, "R2 z64 p30");
  endtask

  task automatic testLargeShift;
    runOne(96, 70, 4, "R6 z96 p70");
    runOne(81, 60, 5, "R6 z81 p60");
    runOne(88, 49, 6, "R6 z88 p49");
  endtask

  task automatic testZeroShift;
    runOne(27, 0, 7, "R5 z27 p0");
    runOne(96, 0, 8, "R5 z96 p0");
  endtask

  task automatic testExtremes;
    runOne(24, 1, 9, "R9 z24 p1");
    runOne(24, 23, 10, "R9 z24 p23");
    runOne(96, 1, 11, "R9 z96 p1");
    runOne(96, 95, 12, "R9 z96 p95");
  endtask

  task automatic testFiller;
    logic [VW-1:0] a;
    logic [VW-1:0] b;
    logic [VW-1:0] firstOut;
    a = makeVec(54, 20);
    b = a;
    for (int k = 54; k < ZMAX; k++) b[k*SYM_W +: SYM_W] = ~a[k*SYM_W +: SYM_W];
    sendOne(a, 54, 33);
    firstOut = outData;
    compareVec(refRot(a, 54, 33), "R3 upper lanes zero");
    sendOne(b, 54, 33);
    compareVec(firstOut, "R4 filler ignored");
  endtask

  task automatic testHold;
    logic [VW-1:0] v;
    logic [VW-1:0] held;
    v = makeVec(48, 30);
    sendOne(v, 48, 11);
    held = refRot(v, 48, 11);
    @(negedge clk);
    inData = makeVec(32, 31); zSize = ZW'(32); shiftAmt = ZW'(3);
    @(negedge clk);
    checkBit(outValid, 1'b0, "R8 valid low when idle");
    compareVec(held, "R8 hold when idle");
  endtask

  task automatic testAllSizes;
    for (int z = 24; z <= 96; z += 4) runOne(z, int'($urandom_range(z - 1, 0)), z, "R7 sweep");
    runOne(27, 26, 40, "R7 z27");
    runOne(54, 41, 41, "R7 z54");
    runOne(81, 12, 42, "R7 z81");
  endtask

  task automatic testRandom;
    int sizes[22];
    for (int j = 0; j < 19; j++) sizes[j] = 24 + 4 * j;
    sizes[19] = 27; sizes[20] = 54; sizes[21] = 81;
    for (int n = 0; n < 200; n++) begin
      int z;
      z = sizes[$urandom_range(21, 0)];
      runOne(z, int'($urandom_range(z - 1, 0)), n + 100, "R2 random");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testSmallShift();
    testLargeShift();
    testZeroShift();
    testExtremes();
    testFiller();
    testHold();
    testAllSizes();
    testRandom();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule